// File: doc/BRIEF.md
# Serial-Clocked Successive-Approximation Sequencer

This block is the digital heart of a serial successive-approximation converter. It has no clock of its own: every state change happens on a falling edge of the host's serial clock, and the active-low chip select resets it asynchronously while high. When chip select drops, the block asks the analog side to power up. It puts the track/hold into track mode and starts driving the serial data line.

Three falling edges later the sample is held, and the block begins a binary search. It presents a trial code to an external DAC and reads back a one-bit comparator decision. It then keeps or clears the trial bit and moves one bit down. Each decision is shifted onto the data line on the same falling edge that makes it, so the result leaves the block with no pipeline delay. Four zero bits lead the result on the line.

Once the whole frame has been clocked out, the data line returns to high impedance and power is released. Raising chip select before that point aborts the frame at once. Resolution is a parameter, and the frame is always four bits longer than the resolution.

Top module: `sar_seq_top`

## Requirements
- R1: While `cs_n` is high, `dac_code` equals mid-scale (only bit RES-1 set), and `sdo_oe`, `pwr_up` and `th_track` are all low.
- R2: When `cs_n` falls, `pwr_up`, `th_track` and `sdo_oe` go high without waiting for a clock edge, and `sdo` is 0.
- R3: `th_track` stays high through the first two `sclk` falling edges after `cs_n` falls, and goes low (hold) on the third.
- R4: After `cs_n` falls, `sdo` carries four zero bits: the first from the `cs_n` fall, the next three after falling edges 1, 2 and 3.
- R5: After falling edge k (4 ≤ k ≤ RES+3), `sdo` holds result bit RES-1-(k-4), so the result leaves MSB first with one new bit per falling edge.
- R6: `cmp_i` = 1 means the analog input is at or above the trial code now on `dac_code`. Each decision keeps (1) or clears (0) the trial bit, and the next lower bit becomes the new trial. The result that is shifted out therefore equals the largest code that the comparator rates at or below the input.
- R7: On falling edge RES+4, `sdo_oe` and `pwr_up` go low and stay low for any further falling edges while `cs_n` stays low.
- R8: Raising `cs_n` before the frame is complete immediately drops `sdo_oe` and `pwr_up` and returns `dac_code` to mid-scale. The next frame then runs normally from its start.
- R9: The frame length is RES+4 falling edges, with RES set by a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; falling edges advance the conversion and the readout |
| cs_n | input | 1 | Active-low chip select; high holds the block in reset |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above `dac_code` |
| th_track | output | 1 | 1 = track/hold tracking, 0 = holding |
| pwr_up | output | 1 | Request to power the analog circuits |
| dac_code | output | RES | Trial code for the DAC |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for the serial data driver |

## Verification
The bench builds the block with RES = 6, which gives a 10-edge frame. Across 64 codes it can model an ideal comparator and sweep every analog input level. Every result bit, the leading zeros, the hold edge and the release edge are then checked against arithmetic on the input value. At this size the bench can also abort after every possible edge count, including the edge just before release, and confirm that a full frame then runs correctly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned LEAD_ZEROS = 4;
    localparam int unsigned HOLD_EDGE  = 3;

    function automatic int unsigned frame_len(input int unsigned res);
        return res + LEAD_ZEROS;
    endfunction

    typedef enum logic [1:0] {
        PH_ACQ     = 2'd0,
        PH_LEAD    = 2'd1,
        PH_RESOLVE = 2'd2,
        PH_DONE    = 2'd3
    } phase_e;

endpackage

// File: rtl/sar_seq_phase.sv
module sar_seq_phase
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES = 12,
    localparam int unsigned FRAME = frame_len(RES),
    localparam int unsigned CW = $clog2(FRAME + 1)
) (
    input  logic          sclk,
    input  logic          cs_n,
    output logic [CW-1:0] edge_cnt,
    output phase_e        phase,
    output logic          resolve_en
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CW'(FRAME)) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.cnt == CW'(FRAME)) begin
            phase = PH_DONE;
        end else if (st_q.cnt < CW'(HOLD_EDGE)) begin
            phase = PH_ACQ;
        end else if (st_q.cnt < CW'(LEAD_ZEROS - 1)) begin
            phase = PH_LEAD;
        end else if (st_q.cnt < CW'(FRAME - 1)) begin
            phase = PH_RESOLVE;
        end else begin
            phase = PH_LEAD;
        end
    end

    assign edge_cnt   = st_q.cnt;
    assign resolve_en = (st_q.cnt >= CW'(LEAD_ZEROS - 1)) && (st_q.cnt < CW'(FRAME - 1));

    AST_CNT_STEP: assert property (@(negedge sclk) disable iff (cs_n)
        (st_q.cnt != CW'(FRAME)) |=> (st_q.cnt == $past(st_q.cnt) + CW'(1))); // R9

    AST_CNT_SAT: assert property (@(negedge sclk) disable iff (cs_n)
        (st_q.cnt == CW'(FRAME)) |=> (st_q.cnt == CW'(FRAME))); // R7

endmodule

// File: rtl/sar_seq_approx.sv
module sar_seq_approx #(
    parameter int unsigned RES = 12
) (
    input  logic           sclk,
    input  logic           cs_n,
    input  logic           resolve_en,
    input  logic           cmp_i,
    output logic [RES-1:0] code
);

    localparam logic [RES-1:0] MID = {1'b1, {(RES-1){1'b0}}};

    typedef struct packed {
        logic [RES-1:0] code;
        logic [RES-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (resolve_en) begin
            st_d.code = (st_q.code & ~st_q.mask)
                      | (cmp_i ? st_q.mask : '0)
                      | (st_q.mask >> 1);
            st_d.mask = st_q.mask >> 1;
        end
    end

    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            st_q.code <= MID;
            st_q.mask <= MID;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

    AST_MASK_ONEHOT: assert property (@(negedge sclk) disable iff (cs_n)
        $onehot0(st_q.mask)); // R6

    AST_TRIAL_SET: assert property (@(negedge sclk) disable iff (cs_n)
        (st_q.mask != '0) |-> ((st_q.code & st_q.mask) != '0)); // R6

    AST_IDLE_MID: assert property (@(posedge sclk) disable iff (!cs_n)
        (st_q.code == MID)); // R1

endmodule

// File: rtl/sar_seq_txbit.sv
module sar_seq_txbit (
    input  logic sclk,
    input  logic cs_n,
    input  logic resolve_en,
    input  logic cmp_i,
    output logic sdo
);

    typedef struct packed {
        logic bit_v;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (resolve_en) begin
            st_d.bit_v = cmp_i;
        end
    end

    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo = st_q.bit_v;

    AST_BIT_FOLLOWS_CMP: assert property (@(negedge sclk) disable iff (cs_n)
        resolve_en |=> (sdo == $past(cmp_i))); // R5

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES = 12
) (
    input  logic           sclk,
    input  logic           cs_n,
    input  logic           cmp_i,
    output logic           th_track,
    output logic           pwr_up,
    output logic [RES-1:0] dac_code,
    output logic           sdo,
    output logic           sdo_oe
);

    localparam int unsigned FRAME = frame_len(RES);
    localparam int unsigned CW = $clog2(FRAME + 1);

    logic [CW-1:0] edge_cnt;
    phase_e        phase;
    logic          resolve_en;
    logic          active;

    sar_seq_phase #(.RES(RES)) u_phase (
        .sclk       (sclk),
        .cs_n       (cs_n),
        .edge_cnt   (edge_cnt),
        .phase      (phase),
        .resolve_en (resolve_en)
    );

    sar_seq_approx #(.RES(RES)) u_approx (
        .sclk       (sclk),
        .cs_n       (cs_n),
        .resolve_en (resolve_en),
        .cmp_i      (cmp_i),
        .code       (dac_code)
    );

    sar_seq_txbit u_txbit (
        .sclk       (sclk),
        .cs_n       (cs_n),
        .resolve_en (resolve_en),
        .cmp_i      (cmp_i),
        .sdo        (sdo)
    );

    assign active   = !cs_n && (phase != PH_DONE);
    assign pwr_up   = active;
    assign sdo_oe   = active;
    assign th_track = !cs_n && (phase == PH_ACQ);

    AST_LEAD_ZERO: assert property (@(negedge sclk) disable iff (cs_n)
        (edge_cnt < CW'(LEAD_ZEROS)) |-> (sdo == 1'b0)); // R4

    AST_HOLD_KEPT: assert property (@(negedge sclk) disable iff (cs_n)
        !th_track |=> !th_track); // R3

    AST_RELEASE_STICKY: assert property (@(negedge sclk) disable iff (cs_n)
        !sdo_oe |=> (!sdo_oe && !pwr_up)); // R7

endmodule

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;

    localparam int RES   = 6;
    localparam int FRAME = RES + 4;
    localparam logic [RES-1:0] MID = {1'b1, {(RES-1){1'b0}}};

    logic           sclk = 1'b0;
    logic           cs_n = 1'b0;
    logic           cmp_i;
    logic           th_track, pwr_up, sdo, sdo_oe;
    logic [RES-1:0] dac_code;
    int             vin = 0;
    int             n_chk = 0;
    int             n_bad = 0;
    bit             finished = 0;

    always #5 sclk = ~sclk;

    assign cmp_i = (vin >= int'(dac_code));

    sar_seq_top #(.RES(RES)) u0 (
        .sclk(sclk), .cs_n(cs_n), .cmp_i(cmp_i), .th_track(th_track),
        .pwr_up(pwr_up), .dac_code(dac_code), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (vin=%0d)", req, act, exp, vin);
        end
    endtask

    function automatic int exp_bit(input int v, input int k);
        if (k < 4) return 0;
        return (v >> (RES - 1 - (k - 4))) & 1;
    endfunction

    task automatic check_idle();
        chk("R1 idle dac_code", int'(dac_code), int'(MID));
        chk("R1 idle sdo_oe", int'(sdo_oe), 0);
        chk("R1 idle pwr_up", int'(pwr_up), 0);
        chk("R1 idle th_track", int'(th_track), 0);
    endtask

    task automatic start_frame();
        @(posedge sclk); #1;
        cs_n = 1'b0;
        #1;
        chk("R2 oe at cs fall", int'(sdo_oe), 1);
        chk("R2 pwr at cs fall", int'(pwr_up), 1);
        chk("R2 track at cs fall", int'(th_track), 1);
        chk("R4 first zero", int'(sdo), 0);
    endtask

    task automatic end_frame();
        @(posedge sclk); #1;
        cs_n = 1'b1;
        #1;
        chk("R8 oe after cs rise", int'(sdo_oe), 0);
        chk("R8 pwr after cs rise", int'(pwr_up), 0);
        chk("R8 dac after cs rise", int'(dac_code), int'(MID));
        @(posedge sclk); #1;
        check_idle();
    endtask

    task automatic full_frame(input int v);
        vin = v;
        start_frame();
        for (int k = 1; k <= FRAME + 2; k++) begin
            @(negedge sclk); #2;
            if (k < FRAME) begin
                chk("R9 oe within frame", int'(sdo_oe), 1);
                chk("R3 track/hold", int'(th_track), (k < 3) ? 1 : 0);
                if (k < 4) chk("R4 leading zero", int'(sdo), 0);
                else chk("R5 R6 result bit", int'(sdo), exp_bit(v, k));
            end else begin
                chk("R7 oe released", int'(sdo_oe), 0);
                chk("R7 power released", int'(pwr_up), 0);
            end
        end
        end_frame();
    endtask

    task automatic abort_frame(input int v, input int edges);
        vin = v;
        start_frame();
        for (int k = 1; k <= edges; k++) begin
            @(negedge sclk); #2;
        end
        end_frame();
    endtask

    initial begin
        #1 cs_n = 1'b1;
        @(posedge sclk); #1;
        check_idle();
        for (int v = 0; v < (1 << RES); v++) begin
            full_frame(v);
        end
        for (int m = 0; m < FRAME; m++) begin
            abort_frame((m * 7 + 3) % (1 << RES), m);
            full_frame((m * 13 + 5) % (1 << RES));
        end
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge sclk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual running expected finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule